// File: doc/BRIEF.md
# Test Vector Bus Master Controller

This block lets an external tester take over an internal system bus through a narrow test port. The port has two request lines, an acknowledge, a 32-bit test data word and a test clock. The block first asks the bus arbiter for the internal bus. Once the bus is granted it raises the acknowledge, and it switches the internal bus clock source to the test clock through a select output.

In test mode the two request lines carry a code that is sampled one cycle ahead. The code classifies the next word on the test data bus as an address vector, a control vector, a write vector or a read vector. The block drives the internal address, transfer type, transfer size and write data to match. It returns read data to the tester one cycle after the read.

For data vectors the block chooses the transfer type itself. The first transfer after a new address is non-sequential. It becomes sequential when a control vector left the size unchanged, and every later transfer in the run is sequential. After each data vector the address steps by the current transfer size.

Top module: `tvb_master`

## Requirements
- R1: Reset (synchronous, active high) clears `tp_ack`, `clk_sel`, `bus_req`, `int_write` and `tp_data_oe`. It sets `int_trans` to IDLE (2'b00), the held address to 0 and the held size code to 2.
- R2: A request code `{tp_req_a,tp_req_b}` = 2'b10, sampled while the block is out of test mode, raises `bus_req` from the next cycle on. `tp_ack` and `clk_sel` go high together one cycle after `bus_gnt` is sampled high while requesting. `bus_req` stays high for as long as test mode lasts.
- R3: In test mode, code 2'b11 sampled while the current vector is not an address vector makes the next cycle an address vector. In that cycle `int_addr` equals `tp_data_in` and `int_trans` is ADDR_ONLY (2'b01).
- R4: Code 2'b11 sampled during an address vector makes the next cycle a control vector. In that cycle `int_size` equals `tp_data_in[1:0]` and `int_trans` is ADDR_ONLY. The new size is kept afterwards.
- R5: Code 2'b10 makes the next cycle a write vector. `int_write` is high, and `int_wdata` equals `tp_data_in` in that cycle.
- R6: Code 2'b01 makes the next cycle a read vector, with `int_write` low. In the following cycle `tp_data_oe` is high and `tp_data_out` holds the `int_rdata` value sampled during the read cycle.
- R7: The first data vector after an address vector is NONSEQ (2'b10). If a control vector in between carried the size already held, that data vector is SEQ (2'b11). Data vectors that follow directly are SEQ.
- R8: A write or read code seen before any address vector has been given is ignored. The next cycle shows IDLE with `int_write` low, and the cycle after that shows `tp_data_oe` low.
- R9: After each data vector the held address advances by 1 << size code (0 is a byte, 1 a halfword, 2 a word, 3 a doubleword).
- R10: Outside test mode `int_trans` is IDLE. Code 2'b00 in test mode makes the next cycle IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tp_req_a | input | 1 | Request line A (high bit of the code) |
| tp_req_b | input | 1 | Request line B (low bit of the code) |
| tp_ack | output | 1 | Test mode acknowledge |
| tp_data_in | input | DW | Test data word from the tester |
| tp_data_out | output | DW | Read data returned to the tester |
| tp_data_oe | output | 1 | Drive enable for the returned read data |
| bus_req | output | 1 | Request for the internal bus |
| bus_gnt | input | 1 | Grant of the internal bus |
| clk_sel | output | 1 | Selects the test clock as the internal bus clock |
| int_addr | output | AW | Internal address |
| int_trans | output | 2 | Transfer type: 00 IDLE, 01 ADDR_ONLY, 10 NONSEQ, 11 SEQ |
| int_size | output | 2 | Transfer size code |
| int_write | output | 1 | Write strobe for a write vector |
| int_wdata | output | DW | Internal write data |
| int_rdata | input | DW | Internal read data |

## Verification
The bench builds the block with the default 32-bit data and address widths. With these widths an address word maps onto the internal address bit for bit, and a word-sized run crosses several increments without truncation. The byte-size run after a changed control vector shows both the NONSEQ/SEQ choice and a one-step address increment. Re-entering test mode after a mid-session reset exercises the ignored data codes before any address.

// File: rtl/tvb_pkg.sv
package tvb_pkg;

    localparam int SZW = 2;
    localparam logic [SZW-1:0] SIZE_RESET = 2'd2;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_ADDR = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    typedef enum logic [2:0] {
        VK_NONE,
        VK_ADDR,
        VK_CTRL,
        VK_WRITE,
        VK_READ
    } vkind_e;

    typedef enum logic [1:0] {
        MD_OFF,
        MD_WAIT,
        MD_TEST
    } mode_e;

    typedef struct packed {
        logic [SZW-1:0] size;
        logic           pend;
        logic           have;
    } ctl_t;

    function automatic vkind_e classify(input logic [1:0] code,
                                        input vkind_e     cur,
                                        input logic       have_addr);
        vkind_e k;
        case (code)
            2'b11:   k = (cur == VK_ADDR) ? VK_CTRL : VK_ADDR;
            2'b10:   k = have_addr ? VK_WRITE : VK_NONE;
            2'b01:   k = have_addr ? VK_READ : VK_NONE;
            default: k = VK_NONE;
        endcase
        return k;
    endfunction

    function automatic logic is_data(input vkind_e k);
        return (k == VK_WRITE) || (k == VK_READ);
    endfunction

endpackage

// File: rtl/tvb_entry.sv
module tvb_entry
    import tvb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] code,
    input  logic       gnt,
    output logic       in_test,
    output logic       bus_req
);

    mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MD_OFF;
        end else begin
            case (mode_q)
                MD_OFF:  if (code == 2'b10) mode_q <= MD_WAIT;
                MD_WAIT: if (gnt) mode_q <= MD_TEST;
                default: mode_q <= MD_TEST;
            endcase
        end
    end

    assign in_test = (mode_q == MD_TEST);
    assign bus_req = (mode_q != MD_OFF);

endmodule

// File: rtl/tvb_decode.sv
module tvb_decode
    import tvb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_test,
    input  logic [1:0] code,
    input  logic       have_addr,
    output vkind_e     cur
);

    vkind_e cur_q;
    logic   have_now;

    assign have_now = have_addr || (cur_q == VK_ADDR) || (cur_q == VK_CTRL);

    always_ff @(posedge clk) begin
        if (rst || !in_test) begin
            cur_q <= VK_NONE;
        end else begin
            cur_q <= classify(code, cur_q, have_now);
        end
    end

    assign cur = cur_q;

endmodule

// File: rtl/tvb_datapath.sv
module tvb_datapath
    import tvb_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  vkind_e         cur,
    input  logic [DW-1:0]  tp_data_in,
    input  logic [DW-1:0]  int_rdata,
    output logic [AW-1:0]  int_addr,
    output trans_e         int_trans,
    output logic [SZW-1:0] int_size,
    output logic           int_write,
    output logic [DW-1:0]  int_wdata,
    output logic [DW-1:0]  tp_data_out,
    output logic           tp_data_oe,
    output logic           have_addr
);

    logic [AW-1:0] addr_q;
    ctl_t          ctl_q;
    logic [DW-1:0] rd_q;
    logic          oe_q;
    logic [AW-1:0] step;
    logic [SZW-1:0] size_word;

    assign size_word = tp_data_in[SZW-1:0];
    assign int_addr  = (cur == VK_ADDR) ? tp_data_in[AW-1:0] : addr_q;
    assign int_size  = (cur == VK_CTRL) ? size_word : ctl_q.size;
    assign int_write = (cur == VK_WRITE);
    assign int_wdata = int_write ? tp_data_in : '0;
    assign step      = AW'(1) << int_size;

    always_comb begin
        case (cur)
            VK_ADDR, VK_CTRL:  int_trans = TR_ADDR;
            VK_WRITE, VK_READ: int_trans = ctl_q.pend ? TR_NSEQ : TR_SEQ;
            default:           int_trans = TR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            ctl_q  <= '{size: SIZE_RESET, pend: 1'b0, have: 1'b0};
            rd_q   <= '0;
            oe_q   <= 1'b0;
        end else begin
            oe_q <= (cur == VK_READ);
            if (cur == VK_READ) rd_q <= int_rdata;
            if (cur == VK_ADDR) begin
                addr_q     <= tp_data_in[AW-1:0];
                ctl_q.pend <= 1'b1;
                ctl_q.have <= 1'b1;
            end else if (cur == VK_CTRL) begin
                ctl_q.size <= size_word;
                if (size_word == ctl_q.size) ctl_q.pend <= 1'b0;
            end else if (is_data(cur)) begin
                addr_q     <= int_addr + step;
                ctl_q.pend <= 1'b0;
            end
        end
    end

    assign tp_data_out = oe_q ? rd_q : '0;
    assign tp_data_oe  = oe_q;
    assign have_addr   = ctl_q.have;

endmodule

// File: rtl/tvb_master.sv
module tvb_master
    import tvb_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tp_req_a,
    input  logic          tp_req_b,
    output logic          tp_ack,
    input  logic [DW-1:0] tp_data_in,
    output logic [DW-1:0] tp_data_out,
    output logic          tp_data_oe,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          clk_sel,
    output logic [AW-1:0] int_addr,
    output logic [1:0]    int_trans,
    output logic [1:0]    int_size,
    output logic          int_write,
    output logic [DW-1:0] int_wdata,
    input  logic [DW-1:0] int_rdata
);

    logic [1:0] code;
    logic       in_test;
    logic       have_addr;
    vkind_e     cur;
    trans_e     trans;

    assign code = {tp_req_a, tp_req_b};

    tvb_entry u_entry (
        .clk     (clk),
        .rst     (rst),
        .code    (code),
        .gnt     (bus_gnt),
        .in_test (in_test),
        .bus_req (bus_req)
    );

    tvb_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .in_test   (in_test),
        .code      (code),
        .have_addr (have_addr),
        .cur       (cur)
    );

    tvb_datapath #(.DW(DW), .AW(AW)) u_dp (
        .clk         (clk),
        .rst         (rst),
        .cur         (cur),
        .tp_data_in  (tp_data_in),
        .int_rdata   (int_rdata),
        .int_addr    (int_addr),
        .int_trans   (trans),
        .int_size    (int_size),
        .int_write   (int_write),
        .int_wdata   (int_wdata),
        .tp_data_out (tp_data_out),
        .tp_data_oe  (tp_data_oe),
        .have_addr   (have_addr)
    );

    assign int_trans = trans;
    assign tp_ack    = in_test;
    assign clk_sel   = in_test;

endmodule

// File: rtl/tvb_master_chk.sv
module tvb_master_chk #(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          tp_ack,
    input logic [DW-1:0] tp_data_out,
    input logic          tp_data_oe,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          clk_sel,
    input logic [AW-1:0] int_addr,
    input logic [1:0]    int_trans,
    input logic [1:0]    int_size,
    input logic          int_write,
    input logic [DW-1:0] int_rdata
);

    AST_ACK_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(tp_ack) |-> $past(bus_gnt) && $past(bus_req)); // R2

    AST_TEST_HOLDS_BUS: assert property (@(posedge clk) disable iff (rst)
        tp_ack |-> bus_req && clk_sel); // R2

    AST_IDLE_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        !tp_ack |-> int_trans == 2'b00); // R10

    AST_WRITE_IS_DATA: assert property (@(posedge clk) disable iff (rst)
        int_write |-> int_trans[1]); // R5

    AST_READ_RETURN: assert property (@(posedge clk) disable iff (rst)
        (int_trans[1] && !int_write) |=> tp_data_oe && tp_data_out == $past(int_rdata)); // R6

    AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        tp_data_oe |-> $past(int_trans[1] && !int_write)); // R6

    AST_SEQ_RUN: assert property (@(posedge clk) disable iff (rst)
        int_trans[1] ##1 int_trans[1] |-> int_trans == 2'b11); // R7

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        int_trans[1] ##1 int_trans[1] |->
            int_addr == $past(int_addr) + (AW'(1) << $past(int_size))); // R9

endmodule

bind tvb_master tvb_master_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tp_ack      (tp_ack),
    .tp_data_out (tp_data_out),
    .tp_data_oe  (tp_data_oe),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .clk_sel     (clk_sel),
    .int_addr    (int_addr),
    .int_trans   (int_trans),
    .int_size    (int_size),
    .int_write   (int_write),
    .int_rdata   (int_rdata)
);

// File: tb/sim_tvb_master.sv
module sim_tvb_master;

    localparam int DW = 32;
    localparam int AW = 32;
    localparam logic [31:0] RD_VAL = 32'h5EED_0042;

    typedef struct packed {
        logic [1:0]  code;
        logic [31:0] data;
        logic [1:0]  etr;
        logic [31:0] eaddr;
        logic        ewr;
        logic [1:0]  esz;
        logic        eoe;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TAB [NV] = '{
        '{2'b11, 32'h0000_0000, 2'b00, 32'h0000_0000, 1'b0, 2'd2, 1'b0},
        '{2'b10, 32'h0000_0100, 2'b01, 32'h0000_0100, 1'b0, 2'd2, 1'b0},
        '{2'b10, 32'hAAAA_0001, 2'b10, 32'h0000_0100, 1'b1, 2'd2, 1'b0},
        '{2'b01, 32'h0000_BBBB, 2'b11, 32'h0000_0104, 1'b1, 2'd2, 1'b0},
        '{2'b00, 32'h0000_0000, 2'b11, 32'h0000_0108, 1'b0, 2'd2, 1'b0},
        '{2'b11, 32'h0000_0000, 2'b00, 32'h0000_010C, 1'b0, 2'd2, 1'b1},
        '{2'b11, 32'h0000_0200, 2'b01, 32'h0000_0200, 1'b0, 2'd2, 1'b0},
        '{2'b10, 32'h0000_0002, 2'b01, 32'h0000_0200, 1'b0, 2'd2, 1'b0},
        '{2'b11, 32'h0000_0055, 2'b11, 32'h0000_0200, 1'b1, 2'd2, 1'b0},
        '{2'b11, 32'h0000_0300, 2'b01, 32'h0000_0300, 1'b0, 2'd2, 1'b0},
        '{2'b10, 32'h0000_0000, 2'b01, 32'h0000_0300, 1'b0, 2'd0, 1'b0},
        '{2'b10, 32'h0000_0001, 2'b10, 32'h0000_0300, 1'b1, 2'd0, 1'b0},
        '{2'b00, 32'h0000_0002, 2'b11, 32'h0000_0301, 1'b1, 2'd0, 1'b0},
        '{2'b00, 32'h0000_0000, 2'b00, 32'h0000_0302, 1'b0, 2'd0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tp_req_a = 1'b0;
    logic          tp_req_b = 1'b0;
    logic          tp_ack;
    logic [DW-1:0] tp_data_in = '0;
    logic [DW-1:0] tp_data_out;
    logic          tp_data_oe;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic          clk_sel;
    logic [AW-1:0] int_addr;
    logic [1:0]    int_trans;
    logic [1:0]    int_size;
    logic          int_write;
    logic [DW-1:0] int_wdata;
    logic [DW-1:0] int_rdata = RD_VAL;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tvb_master #(.DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .tp_req_a(tp_req_a), .tp_req_b(tp_req_b),
        .tp_ack(tp_ack), .tp_data_in(tp_data_in), .tp_data_out(tp_data_out),
        .tp_data_oe(tp_data_oe), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .clk_sel(clk_sel), .int_addr(int_addr), .int_trans(int_trans),
        .int_size(int_size), .int_write(int_write), .int_wdata(int_wdata),
        .int_rdata(int_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] code, input logic [31:0] data);
        @(negedge clk);
        {tp_req_a, tp_req_b} = code;
        tp_data_in = data;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bus_gnt = 1'b0;
        {tp_req_a, tp_req_b} = 2'b00;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic enter();
        step(2'b10, 32'h0);
        step(2'b00, 32'h0);
        check("R2 bus_req", 32'(bus_req), 32'd1);
        check("R2 ack early", 32'(tp_ack), 32'd0);
        check("R10 idle before test", 32'(int_trans), 32'd0);
        bus_gnt = 1'b1;
        step(2'b00, 32'h0);
        check("R2 ack", 32'(tp_ack), 32'd1);
        check("R2 clk_sel", 32'(clk_sel), 32'd1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 ack", 32'(tp_ack), 32'd0);
        check("R1 bus_req", 32'(bus_req), 32'd0);
        check("R1 clk_sel", 32'(clk_sel), 32'd0);
        check("R1 trans", 32'(int_trans), 32'd0);
        check("R1 oe", 32'(tp_data_oe), 32'd0);
        check("R1 size", 32'(int_size), 32'd2);

        enter();

        for (int i = 0; i < NV; i++) begin
            step(TAB[i].code, TAB[i].data);
            check((TAB[i].etr == 2'b01) ? "R3 addr" : "R9 addr", int_addr, TAB[i].eaddr);
            check((TAB[i].etr == 2'b00) ? "R10 trans" : "R7 trans", 32'(int_trans), 32'(TAB[i].etr));
            check("R4 size", 32'(int_size), 32'(TAB[i].esz));
            check("R5 write", 32'(int_write), 32'(TAB[i].ewr));
            if (TAB[i].ewr) check("R5 wdata", int_wdata, TAB[i].data);
            check("R6 oe", 32'(tp_data_oe), 32'(TAB[i].eoe));
            if (TAB[i].eoe) check("R6 rdata", tp_data_out, RD_VAL);
        end

        // R8: data codes before any address are ignored
        do_reset();
        check("R1 ack after reset", 32'(tp_ack), 32'd0);
        enter();
        step(2'b10, 32'h1234_5678);
        step(2'b01, 32'h0);
        check("R8 write ignored trans", 32'(int_trans), 32'd0);
        check("R8 write ignored strobe", 32'(int_write), 32'd0);
        step(2'b00, 32'h0);
        check("R8 read ignored trans", 32'(int_trans), 32'd0);
        step(2'b00, 32'h0);
        check("R8 read ignored oe", 32'(tp_data_oe), 32'd0);

        // R2/R3: address then direct read with a fresh read value
        int_rdata = 32'h0BAD_F00D;
        step(2'b11, 32'h0);
        step(2'b01, 32'h0000_0040);
        check("R3 addr", int_addr, 32'h0000_0040);
        step(2'b00, 32'h0);
        check("R7 read nonseq", 32'(int_trans), 32'd2);
        step(2'b00, 32'h0);
        check("R6 oe", 32'(tp_data_oe), 32'd1);
        check("R6 rdata", tp_data_out, 32'h0BAD_F00D);
        check("R2 bus_req held", 32'(bus_req), 32'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule